// File: doc/BRIEF.md
# Record Group Prefetch Generator

This block sits beside a level-one cache and watches its lookups. Data records in the target region are 64 bytes long, aligned on 64-byte boundaries, and span two 32-byte cache lines. When a read lookup misses on one line of such a record, the block computes the other line of the same record from the physical address. It then offers that line as a prefetch to a non-blocking level-two cache, so both halves of the record arrive together.

Software programs an inclusive lower bound and an exclusive upper bound on the virtual address. It turns the generator on or off through a small write port. One pending prefetch is held in a single-entry slot with a valid/ready handshake. A trigger that finds the slot occupied is counted as a drop. The exception is a trigger that asks for the line already held: it merges silently.

Top module: `record_sibling_prefetch`

## Requirements
- R1: After reset, `pf_valid` is 0, `drop_count` is 0, the generator is off, and both bounds are 0.
- R2: With `cfg_we`=1 at a clock edge, `cfg_sel` picks the target. 0 writes the lower bound, 1 writes the upper bound, 2 writes the on/off bit from `cfg_wdata[0]`, and 3 writes nothing. The new value governs lookups from the next cycle on.
- R3: Only a lookup with `lk_valid`, `lk_read` and `lk_miss` all 1 can trigger. Hits and writes never produce a request.
- R4: A trigger needs lower bound <= `lk_vaddr` < upper bound, compared as unsigned numbers.
- R5: The requested address is `lk_paddr` with bit 5 inverted and bits 4:0 cleared.
- R6: While the generator is off, no new request is produced.
- R7: While `pf_valid`=1 and `pf_ready`=0, `pf_valid` stays 1 and `pf_addr` does not change.
- R8: A trigger that finds the slot busy (valid and not accepted this cycle) with a different address is discarded. `drop_count` rises by one and saturates at its maximum (255 at default width).
- R9: A trigger whose address equals the one held in a busy slot changes nothing and is not counted.
- R10: If the held request is accepted in the same cycle as a new trigger, the new request takes the slot.
- R11: A request appears on `pf_valid`/`pf_addr` in the cycle after the triggering lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 lower bound, 1 upper bound, 2 on/off |
| cfg_wdata | input | 32 | Configuration write data |
| lk_valid | input | 1 | Cache lookup present |
| lk_read | input | 1 | Lookup is a read |
| lk_miss | input | 1 | Lookup missed |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_paddr | input | 32 | Physical address of the lookup |
| pf_ready | input | 1 | Level-two cache accepts the prefetch |
| pf_valid | output | 1 | Prefetch request pending |
| pf_addr | output | 32 | Line address to prefetch |
| drop_count | output | 8 | Saturating count of discarded triggers |

## Verification
The assertions check the following on every cycle. The handshake holds while it is stalled. Any request address is line-aligned. The drop counter never steps by more than one. An idle slot stays idle after a hit, a write, an out-of-window lookup, or any lookup while the generator is off. Only the bench's scenarios can show the rest: the exact companion address, the window edges at both bounds, the choice between drop, merge and replace when the slot is busy, saturation of the counter, and the one-cycle latency of configuration writes.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/rsp_cfg_regs.sv
module rsp_cfg_regs #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [VA_W-1:0] wdata,
  output logic [VA_W-1:0] lo_bound,
  output logic [VA_W-1:0] hi_bound,
  output logic            gen_on
);
  import rsp_pkg::*;

  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_bound <= '0;
      hi_bound <= '0;
      gen_on   <= 1'b0;
    end else if (we) begin
      case (sel_e)
        SEL_LO:   lo_bound <= wdata;
        SEL_HI:   hi_bound <= wdata;
        SEL_CTRL: gen_on   <= wdata[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rsp_trigger.sv
module rsp_trigger #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int LINE_BITS = 5
) (
  input  logic            lk_valid,
  input  logic            lk_read,
  input  logic            lk_miss,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic [PA_W-1:0] lk_paddr,
  input  logic [VA_W-1:0] lo_bound,
  input  logic [VA_W-1:0] hi_bound,
  input  logic            gen_on,
  output logic            read_miss,
  output logic            in_window,
  output logic            trig,
  output logic [PA_W-1:0] comp_addr
);
  function automatic logic window_hit(input logic [VA_W-1:0] va,
                                      input logic [VA_W-1:0] lo,
                                      input logic [VA_W-1:0] hi);
    return (va >= lo) && (va < hi);
  endfunction

  function automatic logic [PA_W-1:0] sibling_of(input logic [PA_W-1:0] pa);
    logic [PA_W-1:0] r;
    r = pa;
    r[LINE_BITS] = ~pa[LINE_BITS];
    r[LINE_BITS-1:0] = '0;
    return r;
  endfunction

  assign read_miss = lk_valid && lk_read && lk_miss;
  assign in_window = window_hit(lk_vaddr, lo_bound, hi_bound);
  assign trig      = read_miss && in_window && gen_on;
  assign comp_addr = sibling_of(lk_paddr);
endmodule

// File: rtl/rsp_slot.sv
module rsp_slot #(
  parameter int PA_W      = 32,
  parameter int LINE_BITS = 5,
  parameter int DROP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [PA_W-1:0]   comp_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [PA_W-1:0]   pf_addr,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic busy, load_ev, merge_ev, drop_ev, pop_ev;

  assign pop_ev   = pf_valid && pf_ready;
  assign busy     = pf_valid && !pf_ready;
  assign load_ev  = trig && !busy;
  assign merge_ev = trig && busy && (comp_addr == pf_addr);
  assign drop_ev  = trig && busy && (comp_addr != pf_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (load_ev) begin
      pf_valid <= 1'b1;
      pf_addr  <= comp_addr;
    end else if (pop_ev) begin
      pf_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      drop_count <= '0;
    else if (drop_ev && drop_count != DROP_MAX)
      drop_count <= drop_count + 1'b1;
  end

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));

  assert_line_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[LINE_BITS-1:0] == '0));

  assert_merge_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    merge_ev |=> ($stable(drop_count) && $stable(pf_addr) && pf_valid));
endmodule

// File: rtl/record_sibling_prefetch.sv
module record_sibling_prefetch #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int LINE_BITS = 5,
  parameter int DROP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [VA_W-1:0]   cfg_wdata,
  input  logic              lk_valid,
  input  logic              lk_read,
  input  logic              lk_miss,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [PA_W-1:0]   lk_paddr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [PA_W-1:0]   pf_addr,
  output logic [DROP_W-1:0] drop_count
);
  logic [VA_W-1:0] lo_bound, hi_bound;
  logic            gen_on;
  logic            read_miss, in_window, trig;
  logic [PA_W-1:0] comp_addr;

  rsp_cfg_regs #(.VA_W(VA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .gen_on(gen_on)
  );

  rsp_trigger #(.VA_W(VA_W), .PA_W(PA_W), .LINE_BITS(LINE_BITS)) u_trig (
    .lk_valid(lk_valid), .lk_read(lk_read), .lk_miss(lk_miss),
    .lk_vaddr(lk_vaddr), .lk_paddr(lk_paddr),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .gen_on(gen_on),
    .read_miss(read_miss), .in_window(in_window), .trig(trig),
    .comp_addr(comp_addr)
  );

  rsp_slot #(.PA_W(PA_W), .LINE_BITS(LINE_BITS), .DROP_W(DROP_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .trig(trig), .comp_addr(comp_addr),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .drop_count(drop_count)
  );

  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_valid && !read_miss) |=> !pf_valid);

  assert_window_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_valid && !in_window) |=> !pf_valid);

  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_valid && !gen_on) |=> !pf_valid);
endmodule

// File: tb/tb_record_sibling_prefetch.sv
module tb_record_sibling_prefetch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic        lk_valid = 1'b0, lk_read = 1'b0, lk_miss = 1'b0;
  logic [31:0] lk_vaddr = '0, lk_paddr = '0;
  logic        pf_ready = 1'b0;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic [7:0]  drop_count;

  record_sibling_prefetch dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_read(lk_read),
    .lk_miss(lk_miss), .lk_vaddr(lk_vaddr), .lk_paddr(lk_paddr),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .drop_count(drop_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string phase = "R1";

  // behavioural reference
  bit          m_valid;
  bit [31:0]   m_addr, m_lo, m_hi;
  bit          m_on;
  int          m_drop;

  always @(posedge clk) begin
    automatic bit stalled = m_valid && !pf_ready;
    automatic bit fire = lk_valid && lk_read && lk_miss && m_on &&
                         (lk_vaddr >= m_lo) && (lk_vaddr < m_hi);
    automatic bit [31:0] want = (lk_paddr ^ 32'h20) & ~32'h1F;
    if (!rst_n) begin
      m_valid <= 0; m_addr <= 0; m_lo <= 0; m_hi <= 0; m_on <= 0; m_drop <= 0;
    end else begin
      if (fire && !stalled) begin
        m_valid <= 1; m_addr <= want;
      end else if (m_valid && pf_ready) m_valid <= 0;
      if (fire && stalled && want != m_addr && m_drop < 255) m_drop <= m_drop + 1;
      if (cfg_we) begin
        if (cfg_sel == 2'd0) m_lo <= cfg_wdata;
        else if (cfg_sel == 2'd1) m_hi <= cfg_wdata;
        else if (cfg_sel == 2'd2) m_on <= cfg_wdata[0];
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({phase, " pf_valid"}, 64'(pf_valid), 64'(m_valid));
      if (m_valid) chk({phase, " pf_addr"}, 64'(pf_addr), 64'(m_addr));
      chk({phase, " drop_count"}, 64'(drop_count), 64'(m_drop));
    end
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cfg(int sel, logic [31:0] d);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_sel = 2'd3;
  endtask

  task automatic look(logic [31:0] va, logic [31:0] pa, bit rd, bit ms);
    lk_valid = 1; lk_read = rd; lk_miss = ms; lk_vaddr = va; lk_paddr = pa;
    @(negedge clk);
    lk_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset valid", 64'(pf_valid), 0);
    chk("R1 reset drops", 64'(drop_count), 0);

    // R1: off and empty window after reset; R2: bounds without enable
    look(32'h0, 32'h8000, 1, 1);
    chk("R1 idle after reset", 64'(pf_valid), 0);
    phase = "R2";
    cfg(0, 32'h1000);
    cfg(1, 32'h2000);
    cfg(3, 32'h1);
    look(32'h1800, 32'h8000, 1, 1);
    chk("R2 sel3 no enable", 64'(pf_valid), 0);
    cfg(2, 32'h1);

    // R11 + R5
    pf_ready = 1;
    phase = "R5";
    look(32'h1000, 32'h0000_8040, 1, 1);
    chk("R11 next cycle valid", 64'(pf_valid), 1);
    chk("R5 sibling upper", 64'(pf_addr), 64'h8060);
    @(negedge clk);
    look(32'h1100, 32'h0000_8075, 1, 1);
    chk("R5 sibling lower", 64'(pf_addr), 64'h8040);
    @(negedge clk);

    // R3
    phase = "R3";
    look(32'h1200, 32'h9000, 1, 0);
    chk("R3 hit quiet", 64'(pf_valid), 0);
    look(32'h1200, 32'h9000, 0, 1);
    chk("R3 write miss quiet", 64'(pf_valid), 0);

    // R4
    phase = "R4";
    look(32'h1FFF, 32'hA000, 1, 1);
    chk("R4 last inside", 64'(pf_valid), 1);
    @(negedge clk);
    look(32'h2000, 32'hA000, 1, 1);
    chk("R4 end exclusive", 64'(pf_valid), 0);
    look(32'h0FFF, 32'hA000, 1, 1);
    chk("R4 below start", 64'(pf_valid), 0);

    // R7 R8 R9
    phase = "R8";
    pf_ready = 0;
    look(32'h1000, 32'hB000, 1, 1);
    look(32'h1040, 32'hC000, 1, 1);
    chk("R8 drop counted", 64'(drop_count), 1);
    chk("R7 held addr", 64'(pf_addr), 64'hB020);
    look(32'h1040, 32'hB000, 1, 1);
    chk("R9 merge no drop", 64'(drop_count), 1);
    repeat (3) @(negedge clk);
    chk("R7 still valid", 64'(pf_valid), 1);

    // R10: accept and trigger together
    phase = "R10";
    pf_ready = 1;
    look(32'h1000, 32'hD020, 1, 1);
    chk("R10 replaced", 64'(pf_addr), 64'hD000);
    @(negedge clk);

    // R6
    phase = "R6";
    cfg(2, 32'h0);
    look(32'h1000, 32'hE000, 1, 1);
    chk("R6 off quiet", 64'(pf_valid), 0);
    cfg(2, 32'h1);

    // R8 saturation
    phase = "R8 sat";
    pf_ready = 0;
    look(32'h1000, 32'hF000, 1, 1);
    for (int i = 0; i < 270; i++) look(32'h1000, 32'h10000 + 32'(i) * 64, 1, 1);
    chk("R8 saturated", 64'(drop_count), 255);
    pf_ready = 1;
    repeat (3) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule